// File: doc/BRIEF.md
# Receiver Frame-Rate and Lock Monitor

This block sits beside the front end of a two-channel digital audio receiver and runs on a fast generated clock. That clock must run at more than 768 times the audio sample rate. The front end supplies three one-cycle strobes: one for each recovered frame start, one for each transition seen on the input line, and one for each preamble error. From these strobes the monitor measures the frame period, decides whether the receiver is locked, and notices when the input goes silent. It also shuts the receiver down after a run of preamble errors when that option is selected.

The result is a 32-bit receiver status word and two one-cycle event strobes, one for lock gained and one for lock lost. Software finds the sample rate as the generated clock rate divided by 32 times the frame-size field. A zero field, or a set unlocked bit, means the rate is unknown.

Top module: `spdif_rate_lock_mon`

## Requirements
- R1: After reset the status word reads 0x00000001 and both event strobes are low. Status bit 0 is 1 whenever the receiver is not locked.
- R2: The frame size is the number of generated-clock cycles between two consecutive frame starts, divided by PRESCALE (32) and rounded down. Status bits 16 upward (IFS_W bits) show the last such size while locked and read 0 while unlocked. Status bits 4 to 15 and 28 to 31 always read 0.
- R3: The block declares lock once LOCK_RUN (4) consecutive frame sizes each differ from the one before by no more than TOL (1) unit. The first frame start after a loss of reference only sets the reference. The lock strobe goes high for exactly one cycle, in the same cycle that bit 0 clears.
- R4: While locked, a frame size that differs from the previous one by more than TOL drops lock and sets the bad-format bit (bit 1). Bit 1 clears when lock is next gained.
- R5: A frame size that saturates at all ones sets the low-frequency bit (bit 2), drops lock and restarts qualification. The next frame size that is not saturated clears bit 2.
- R6: When IDLE_LIM cycles pass with no line transition, the no-signal bit (bit 3) is set, lock is dropped and the frame reference is discarded. Bit 3 clears in the cycle after the next transition.
- R7: When the auto-restart input is 1, PE_LIMIT (3) preamble errors with no clean frame start between them force the unlocked state and restart qualification. A frame start without an error resets the count.
- R8: When the auto-restart input is 0, preamble errors have no effect on lock or on the status word.
- R9: The loss strobe goes high for exactly one cycle each time the block moves from locked to unlocked, in the cycle that bit 0 sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Generated sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start | input | 1 | One-cycle strobe at each recovered frame start |
| line_edge | input | 1 | One-cycle strobe at each transition of the input line |
| preamble_err | input | 1 | One-cycle strobe at each preamble error |
| auto_restart_en | input | 1 | 1: unlock after PE_LIMIT consecutive preamble errors |
| status_word | output | 32 | Bit 0 unlocked, 1 bad format, 2 low frequency, 3 no signal, 16+ frame size |
| lock_evt | output | 1 | One-cycle strobe when lock is gained |
| loss_evt | output | 1 | One-cycle strobe when lock is lost |

## Verification
Every result is registered. A frame start, error or transition sampled at a rising edge shows in the status word and event strobes straight after that same edge. The no-signal bit appears at the edge that completes IDLE_LIM transition-free cycles. The bench runs a behavioural model that updates on each rising edge from the same inputs. It compares the full status word and both strobes at every falling edge, so a result that arrives one cycle early or late is caught. Targeted checks are read out partway through each frame, well clear of any edge that could change them.

// File: rtl/spdif_mon_pkg.sv
package spdif_mon_pkg;
   localparam int STATUS_W    = 32;
   localparam int ST_UNLOCKED = 0;
   localparam int ST_BADFMT   = 1;
   localparam int ST_LOWFREQ  = 2;
   localparam int ST_NOSIG    = 3;
   localparam int ST_SIZE_LSB = 16;

   typedef struct packed {
      logic locked;
      logic bad_fmt;
      logic low_freq;
   } qual_flags_t;
endpackage

// File: rtl/frame_period_meter.sv
module frame_period_meter #(
   parameter int PRESCALE = 32,
   parameter int PER_W    = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start,
   output logic [PER_W-1:0] period
);
   localparam int SH = $clog2(PRESCALE);
   localparam int CW = PER_W + SH;
   localparam logic [CW-1:0] CMAX = {CW{1'b1}};

   initial begin
      assert ((PRESCALE & (PRESCALE - 1)) == 0 && PRESCALE >= 1)
         else $error("PRESCALE must be a power of two");
      assert (PER_W >= 2) else $error("PER_W too small");
   end

   logic [CW-1:0] cyc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cyc_q <= '0;
      else if (frame_start) cyc_q <= CW'(1);
      else if (cyc_q != CMAX) cyc_q <= cyc_q + 1'b1;
   end

   assign period = cyc_q[CW-1:SH];

   a_r2_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> cyc_q == CW'(1));
   a_r5_hold_saturated: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_start && cyc_q == CMAX) |=> cyc_q == CMAX);
endmodule

// File: rtl/line_activity_watch.sv
module line_activity_watch #(
   parameter int IDLE_LIM = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_edge,
   output logic no_signal
);
   localparam int IW = $clog2(IDLE_LIM + 1);
   localparam logic [IW-1:0] LIM = IW'(IDLE_LIM);

   initial assert (IDLE_LIM >= 2) else $error("IDLE_LIM too small");

   logic [IW-1:0] idle_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          idle_q <= '0;
      else if (line_edge)  idle_q <= '0;
      else if (idle_q != LIM) idle_q <= idle_q + 1'b1;
   end

   assign no_signal = (idle_q == LIM);

   a_r6_edge_clears: assert property (@(posedge clk) disable iff (!rst_n)
      line_edge |=> !no_signal);
endmodule

// File: rtl/lock_qualifier.sv
module lock_qualifier
   import spdif_mon_pkg::*;
#(
   parameter int PER_W    = 12,
   parameter int LOCK_RUN = 4,
   parameter int TOL      = 1,
   parameter int PE_LIMIT = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start,
   input  logic [PER_W-1:0] period,
   input  logic             no_signal,
   input  logic             preamble_err,
   input  logic             auto_restart_en,
   output qual_flags_t      flags,
   output logic [PER_W-1:0] size,
   output logic             lock_evt,
   output logic             loss_evt
);
   localparam int RW = $clog2(LOCK_RUN + 1);
   localparam logic [RW-1:0] RUN_FULL = RW'(LOCK_RUN);
   localparam logic [PER_W-1:0] TOL_V = PER_W'(TOL);
   localparam logic [PER_W-1:0] SAT_V = {PER_W{1'b1}};

   initial begin
      assert (LOCK_RUN >= 2) else $error("LOCK_RUN must be at least 2");
      assert (TOL >= 0) else $error("TOL must not be negative");
      assert (PE_LIMIT >= 0) else $error("PE_LIMIT must not be negative");
   end

   qual_flags_t      fl_q, fl_d;
   logic [RW-1:0]    run_q, run_d;
   logic             have_q, have_d;
   logic [PER_W-1:0] prev_q, prev_d, size_q, size_d;
   logic [PER_W-1:0] diff;
   logic             in_tol, restart;

   assign diff = (period >= prev_q) ? period - prev_q : prev_q - period;

   generate
      if (TOL == 0) begin : g_exact
         assign in_tol = (period == prev_q);
      end else begin : g_window
         assign in_tol = (diff <= TOL_V);
      end

      if (PE_LIMIT > 0) begin : g_autorst
         localparam int PW = $clog2(PE_LIMIT > 1 ? PE_LIMIT : 2);
         localparam logic [PW-1:0] PE_TOP = PW'(PE_LIMIT - 1);
         logic [PW-1:0] pe_q;
         assign restart = auto_restart_en && preamble_err && (pe_q == PE_TOP);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            pe_q <= '0;
            else if (restart)      pe_q <= '0;
            else if (preamble_err) pe_q <= (pe_q == PE_TOP) ? pe_q : pe_q + 1'b1;
            else if (frame_start)  pe_q <= '0;
         end
      end else begin : g_no_autorst
         assign restart = 1'b0;
      end
   endgenerate

   always_comb begin
      fl_d   = fl_q;
      run_d  = run_q;
      have_d = have_q;
      prev_d = prev_q;
      size_d = size_q;
      if (no_signal || restart) begin
         fl_d.locked = 1'b0;
         run_d       = '0;
         have_d      = 1'b0;
      end else if (frame_start) begin
         have_d = 1'b1;
         if (!have_q) begin
            run_d = '0;
         end else if (period == SAT_V) begin
            fl_d.low_freq = 1'b1;
            fl_d.locked   = 1'b0;
            run_d         = '0;
         end else begin
            fl_d.low_freq = 1'b0;
            prev_d        = period;
            if (run_q == '0 || in_tol) begin
               run_d = (run_q == RUN_FULL) ? run_q : run_q + 1'b1;
            end else begin
               run_d = RW'(1);
               if (fl_q.locked) fl_d.bad_fmt = 1'b1;
               fl_d.locked = 1'b0;
            end
            if (run_d == RUN_FULL) begin
               fl_d.locked = 1'b1;
               size_d      = period;
               if (!fl_q.locked) fl_d.bad_fmt = 1'b0;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fl_q     <= '0;
         run_q    <= '0;
         have_q   <= 1'b0;
         prev_q   <= '0;
         size_q   <= '0;
         lock_evt <= 1'b0;
         loss_evt <= 1'b0;
      end else begin
         fl_q     <= fl_d;
         run_q    <= run_d;
         have_q   <= have_d;
         prev_q   <= prev_d;
         size_q   <= size_d;
         lock_evt <= fl_d.locked && !fl_q.locked;
         loss_evt <= !fl_d.locked && fl_q.locked;
      end
   end

   assign flags = fl_q;
   assign size  = size_q;

   a_r3_lock_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      lock_evt |-> $rose(fl_q.locked));
   a_r9_loss_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      loss_evt |-> $fell(fl_q.locked));
   a_r3_run_full_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
      fl_q.locked |-> run_q == RUN_FULL);
   a_r7_restart_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !fl_q.locked);
endmodule

// File: rtl/spdif_rate_lock_mon.sv
module spdif_rate_lock_mon
   import spdif_mon_pkg::*;
#(
   parameter int PRESCALE = 32,
   parameter int IFS_W    = 12,
   parameter int LOCK_RUN = 4,
   parameter int TOL      = 1,
   parameter int IDLE_LIM = 4096,
   parameter int PE_LIMIT = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                frame_start,
   input  logic                line_edge,
   input  logic                preamble_err,
   input  logic                auto_restart_en,
   output logic [STATUS_W-1:0] status_word,
   output logic                lock_evt,
   output logic                loss_evt
);
   initial assert (IFS_W <= STATUS_W - ST_SIZE_LSB)
      else $error("IFS_W does not fit the status word");

   logic [IFS_W-1:0] period, size;
   logic             no_signal;
   qual_flags_t      flags;

   frame_period_meter #(.PRESCALE(PRESCALE), .PER_W(IFS_W)) u_meter (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .period(period));

   line_activity_watch #(.IDLE_LIM(IDLE_LIM)) u_watch (
      .clk(clk), .rst_n(rst_n), .line_edge(line_edge), .no_signal(no_signal));

   lock_qualifier #(.PER_W(IFS_W), .LOCK_RUN(LOCK_RUN), .TOL(TOL),
                    .PE_LIMIT(PE_LIMIT)) u_qual (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .period(period),
      .no_signal(no_signal), .preamble_err(preamble_err),
      .auto_restart_en(auto_restart_en), .flags(flags), .size(size),
      .lock_evt(lock_evt), .loss_evt(loss_evt));

   always_comb begin
      status_word                          = '0;
      status_word[ST_UNLOCKED]             = !flags.locked;
      status_word[ST_BADFMT]               = flags.bad_fmt;
      status_word[ST_LOWFREQ]              = flags.low_freq;
      status_word[ST_NOSIG]                = no_signal;
      status_word[ST_SIZE_LSB +: IFS_W]    = flags.locked ? size : '0;
   end

   a_r6_silence_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
      no_signal |=> status_word[ST_UNLOCKED]);
   a_r2_size_zero_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
      loss_evt |-> status_word[ST_SIZE_LSB +: IFS_W] == '0);
endmodule

// File: tb/tb_spdif_rate_lock_mon.sv
module tb_spdif_rate_lock_mon;
   localparam int PRE  = 32;
   localparam int W    = 8;
   localparam int RUN  = 4;
   localparam int TOLV = 1;
   localparam int IDLE = 512;
   localparam int PEL  = 3;
   localparam int CMAX = (1 << (W + 5)) - 1;
   localparam int SATP = (1 << W) - 1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic fs = 1'b0, le = 1'b0, pe = 1'b0, ae = 1'b0;
   logic [31:0] st;
   logic levt, lossevt;

   int checks = 0, bad = 0, cyc = 0, nlock = 0, nloss = 0;
   bit sig_on = 1'b1;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   spdif_rate_lock_mon #(.PRESCALE(PRE), .IFS_W(W), .LOCK_RUN(RUN), .TOL(TOLV),
      .IDLE_LIM(IDLE), .PE_LIMIT(PEL)) dut (
      .clk(clk), .rst_n(rst_n), .frame_start(fs), .line_edge(le),
      .preamble_err(pe), .auto_restart_en(ae), .status_word(st),
      .lock_evt(levt), .loss_evt(lossevt));

   // behavioural reference model
   int m_cnt, m_prev, m_run, m_ifs, m_pe, m_idle;
   bit m_have, m_lock, m_bad, m_low, m_le, m_lo;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_prev = 0; m_run = 0; m_ifs = 0; m_pe = 0; m_idle = 0;
         m_have = 0; m_lock = 0; m_bad = 0; m_low = 0; m_le = 0; m_lo = 0;
      end else begin
         bit was, silent, rst_q;
         int per, d;
         was = m_lock;
         silent = (m_idle == IDLE);
         per = m_cnt / PRE;
         rst_q = ae && pe && (m_pe == PEL - 1);
         if (rst_q) m_pe = 0;
         else if (pe) m_pe = (m_pe < PEL - 1) ? m_pe + 1 : m_pe;
         else if (fs) m_pe = 0;
         if (silent || rst_q) begin
            m_lock = 0; m_run = 0; m_have = 0;
         end else if (fs) begin
            if (!m_have) m_run = 0;
            else if (per == SATP) begin
               m_low = 1; m_lock = 0; m_run = 0;
            end else begin
               m_low = 0;
               d = per - m_prev; if (d < 0) d = -d;
               m_prev = per;
               if (m_run == 0 || d <= TOLV) m_run = (m_run < RUN) ? m_run + 1 : RUN;
               else begin
                  m_run = 1;
                  if (m_lock) m_bad = 1;
                  m_lock = 0;
               end
               if (m_run == RUN) begin
                  if (!m_lock) m_bad = 0;
                  m_lock = 1; m_ifs = per;
               end
            end
            m_have = 1;
         end
         m_cnt  = fs ? 1 : (m_cnt < CMAX ? m_cnt + 1 : CMAX);
         m_idle = le ? 0 : (m_idle < IDLE ? m_idle + 1 : IDLE);
         m_le = m_lock && !was;
         m_lo = !m_lock && was;
      end
   end

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // per-cycle comparison against the model, away from the rising edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R1 unlocked bit", int'(st[0]), int'(!m_lock));
         chk("R4 bad-format bit", int'(st[1]), int'(m_bad));
         chk("R5 low-frequency bit", int'(st[2]), int'(m_low));
         chk("R6 no-signal bit", int'(st[3]), int'(m_idle == IDLE));
         chk("R2 frame size field", int'(st[16 +: W]), m_lock ? m_ifs : 0);
         chk("R2 unused bits", int'({st[31:16+W], st[15:4]}), 0);
         chk("R3 lock strobe", int'(levt), int'(m_le));
         chk("R9 loss strobe", int'(lossevt), int'(m_lo));
         if (levt) nlock++;
         if (lossevt) nloss++;
      end
   end

   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         le = sig_on && (cyc % 8 == 0);
      end
   end

   task automatic frame_pe(int p, int nerr);
      @(negedge clk); fs = 1'b1;
      @(negedge clk); fs = 1'b0;
      for (int i = 1; i < p; i++) begin
         pe = (i % 2 == 0) && (i / 2 <= nerr) && (i >= 2);
         if (i < p - 1) @(negedge clk);
      end
      pe = 1'b0;
   endtask

   task automatic frame(int p);
      frame_pe(p, 0);
   endtask

   task automatic wait_cyc(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin
      wait_cyc(5);
      chk("R1 reset status", int'(st), 1);
      chk("R1 reset strobes", int'({levt, lossevt}), 0);
      rst_n = 1'b1;
      wait_cyc(3);
      // R3: lock after four consistent periods of 800 cycles (25 units)
      for (int k = 0; k < 5; k++) frame(800);
      chk("R3 locked with size 25", int'(st), 25 << 16);
      chk("R3 one lock strobe", nlock, 1);
      // R2: jitter inside tolerance keeps lock, size follows
      frame(831); frame(832); frame(900);
      chk("R2 size tracks 26", int'(st), 26 << 16);
      // R4: jump by 2 units drops lock, sets bad format
      frame(1000);
      chk("R4 bad format and unlocked", int'(st), 3);
      chk("R9 one loss strobe", nloss, 1);
      for (int k = 0; k < 4; k++) frame(1000);
      chk("R4 relock clears bad format", int'(st), 31 << 16);
      // R8: errors ignored with auto restart off
      ae = 1'b0;
      frame_pe(1000, 3);
      chk("R8 errors ignored", int'(st), 31 << 16);
      // R7: interrupted error runs do not restart
      ae = 1'b1;
      frame_pe(1000, 2); frame_pe(1000, 1);
      chk("R7 broken error run keeps lock", int'(st), 31 << 16);
      frame_pe(1000, 3);
      chk("R7 three errors force unlock", int'(st), 1);
      chk("R9 loss strobe after restart", nloss, 2);
      ae = 1'b0;
      for (int k = 0; k < 5; k++) frame(1000);
      chk("R3 relock after restart", int'(st), 31 << 16);
      chk("R3 lock strobe count", nlock, 3);
      // R5: period beyond the field range
      frame(8200); frame(1000);
      chk("R5 low frequency flagged", int'(st), 5);
      frame(1000);
      chk("R5 low frequency cleared", int'(st), 1);
      for (int k = 0; k < 3; k++) frame(1000);
      chk("R3 locked before silence", int'(st), 31 << 16);
      // R6: silence
      sig_on = 1'b0;
      wait_cyc(600);
      chk("R6 no signal flagged", int'(st), 9);
      chk("R9 loss strobe on silence", nloss, 4);
      sig_on = 1'b1;
      wait_cyc(20);
      chk("R6 no signal cleared", int'(st), 1);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule